// File: doc/BRIEF.md
# DMA Line Request Splitter

This block takes one DMA transfer at a time, described by a byte start address, a byte count and a direction flag, and turns it into a sequence of line-sized transactions toward a line-level memory port. The first transaction runs from the unaligned start address up to the next line boundary, or less if the transfer is shorter. Every later transaction begins on a line boundary and covers a full line, or whatever remains. Only one transaction is outstanding at any moment. The next one leaves only after the previous one has returned.

Write bytes arrive on a valid/ready byte stream. The block gathers each chunk's bytes into a one-line buffer, then presents the line with byte enables. The input stream stalls (ready low) whenever the block is not filling a chunk. Read lines come back as a single-cycle data pulse and leave on a valid/ready byte stream in address order. The consumer may hold ready low for as long as it likes; the next read transaction is held back until the current chunk has been fully consumed. The downstream request holds its valid and all of its fields steady until ready is seen.

A transfer offered while the block is busy is turned away rather than queued. The requester is then told to retry when the block finishes. A drain input asks the block to report when nothing is outstanding.

Top module: `dma_line_splitter`

## Requirements
- R1: A request offered while idle is accepted in the same cycle (`req_accept` high, `req_refuse` low), and `busy` is high from the next cycle on.
- R2: A request offered while busy is refused in the same cycle (`req_refuse` high, `req_accept` low). It has no effect on the transfer in progress: that transfer's later transactions keep their original addresses and lengths.
- R3: The first transaction carries line offset equal to the start address modulo LINE_BYTES. Its length is the smaller of the total length and LINE_BYTES minus that offset. `mem_line_addr` is the start address with its low log2(LINE_BYTES) bits cleared.
- R4: Each later transaction carries offset 0 and line address equal to start address plus bytes already sent, with the low bits cleared. Its length is the smaller of the remaining bytes and LINE_BYTES.
- R5: `mem_valid` and the request fields stay constant until `mem_ready`. No new transaction is raised while one is awaiting its acknowledge or data. A transfer uses exactly ceil((start offset + length) / LINE_BYTES) transactions.
- R6: For a write (`req_write`=1, `mem_store`=1), `mem_wbe` bit j is 1 exactly for offset <= j < offset+length. Byte j of `mem_wdata` (bits 8j+7..8j) holds the write-stream byte for address line_addr+j, with stream bytes taken in ascending address order.
- R7: For a read, the bytes of each returned line from the chunk's offset onward leave on the read stream in ascending address order, one per accepted handshake. Exactly the requested length is emitted.
- R8: `busy` falls on the clock edge at which the last chunk completes: the acknowledge for a write, or the last byte accepted on the read stream for a read. `done` pulses for one cycle, one cycle after `busy` falls.
- R9: `retry` pulses together with `done` if and only if a request was refused during that transfer.
- R10: `drained` is high only while `drain_req` is high and no transfer is outstanding. It follows one cycle after the condition changes.
- R11: After reset `busy`, `mem_valid`, `wdat_ready`, `rdat_valid`, `done`, `retry` and `drained` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer offered this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, at least 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_accept | output | 1 | Offered transfer taken |
| req_refuse | output | 1 | Offered transfer turned away |
| busy | output | 1 | A transfer is outstanding |
| done | output | 1 | Completion pulse |
| retry | output | 1 | Pulse telling a refused requester to retry |
| drain_req | input | 1 | Drain wanted |
| drained | output | 1 | Drain wanted and nothing outstanding |
| wdat_valid | input | 1 | Write byte present |
| wdat_ready | output | 1 | Block takes a write byte |
| wdat_byte | input | 8 | Write byte |
| rdat_valid | output | 1 | Read byte present |
| rdat_ready | input | 1 | Consumer takes the read byte |
| rdat_byte | output | 8 | Read byte |
| mem_valid | output | 1 | Line transaction presented |
| mem_ready | input | 1 | Line port takes the transaction |
| mem_line_addr | output | ADDR_W | Line-aligned address |
| mem_offset | output | log2(LINE_BYTES) | First byte within the line |
| mem_len | output | log2(LINE_BYTES)+1 | Bytes in this transaction |
| mem_store | output | 1 | 1 = store, 0 = load |
| mem_wdata | output | 8*LINE_BYTES | Store line data |
| mem_wbe | output | LINE_BYTES | Store byte enables |
| mem_ack | input | 1 | Store completion pulse |
| mem_rvalid | input | 1 | Load data pulse |
| mem_rdata | input | 8*LINE_BYTES | Load line data |

## Verification
The checks inside the design assume a well-behaved line port. `mem_ack` and `mem_rvalid` arrive only after the transaction was taken and before another is raised, each as a single pulse matching the transaction's direction. Transfer lengths are non-zero, and start plus length does not wrap the address space. The bench's memory model answers each accepted transaction exactly once, a few cycles later, with the matching pulse. It only issues non-zero lengths in a small address window. It stalls the line port and the read stream on a fixed pattern, so that the hold-steady rules are exercised without breaking these assumptions.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_SEND
  } dls_state_e;
endpackage

// File: rtl/dls_chunk_calc.sv
// Sizes the next line transaction from the transfer start, total and progress.
module dls_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_bytes,
  output logic [ADDR_W-1:0] line_addr,
  output logic [OFF_W-1:0]  offset,
  output logic [CNT_W-1:0]  chunk_len
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  room;
  logic              first;

  always_comb begin
    first     = (done_bytes == '0);
    cur_addr  = start_addr + ADDR_W'(done_bytes);
    line_addr = cur_addr & ~LOW_MASK;
    offset    = first ? start_addr[OFF_W-1:0] : '0;
    room      = CNT_W'(LINE_BYTES) - {1'b0, offset};
    remain    = total_len - done_bytes;
    chunk_len = (remain < LEN_W'(room)) ? CNT_W'(remain) : room;
  end
endmodule

// File: rtl/dls_line_buf.sv
// One line of staging storage: byte writes from the stream, whole-line loads
// from the memory port, byte reads toward the stream.
module dls_line_buf #(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              put_en,
  input  logic [OFF_W-1:0]  put_idx,
  input  logic [7:0]        put_byte,
  input  logic              load_en,
  input  logic [LINE_W-1:0] load_line,
  input  logic [OFF_W-1:0]  get_idx,
  output logic [7:0]        get_byte,
  output logic [LINE_W-1:0] line_q
);
  always_ff @(posedge clk) begin
    if (load_en) begin
      line_q <= load_line;
    end else if (put_en) begin
      line_q[{put_idx, 3'b000} +: 8] <= put_byte;
    end
  end

  assign get_byte = line_q[{get_idx, 3'b000} +: 8];
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              req_accept,
  output logic              req_refuse,
  output logic              busy,
  output logic              done,
  output logic              retry,
  input  logic              drain_req,
  output logic              drained,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [7:0]        wdat_byte,
  output logic              rdat_valid,
  input  logic              rdat_ready,
  output logic [7:0]        rdat_byte,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_line_addr,
  output logic [OFF_W-1:0]  mem_offset,
  output logic [CNT_W-1:0]  mem_len,
  output logic              mem_store,
  output logic [LINE_W-1:0] mem_wdata,
  output logic [LINE_BYTES-1:0] mem_wbe,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata
);
  dls_state_e        state_q, state_n;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q, issued_q, completed_q;
  logic              wr_q;
  logic [OFF_W-1:0]  idx_q, ch_off_q;
  logic [CNT_W-1:0]  ch_len_q;
  logic              finish_now, finish_q, done_q, retry_q, refused_q, drained_q;

  logic [ADDR_W-1:0] calc_line;
  logic [OFF_W-1:0]  calc_off;
  logic [CNT_W-1:0]  calc_len;
  logic              fill_last, send_last, chunk_back;
  logic [LINE_W-1:0] buf_line;

  // ---------------- chunk sizing ----------------
  dls_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .start_addr(start_q),
    .total_len (len_q),
    .done_bytes(completed_q),
    .line_addr (calc_line),
    .offset    (calc_off),
    .chunk_len (calc_len)
  );

  // ---------------- staging line ----------------
  dls_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk      (clk),
    .put_en   (state_q == ST_FILL && wdat_valid),
    .put_idx  (calc_off + idx_q),
    .put_byte (wdat_byte),
    .load_en  (state_q == ST_WAIT && !wr_q && mem_rvalid),
    .load_line(mem_rdata),
    .get_idx  (ch_off_q + idx_q),
    .get_byte (rdat_byte),
    .line_q   (buf_line)
  );

  // ---------------- port decode ----------------
  assign busy       = (state_q != ST_IDLE);
  assign req_accept = req_valid && !busy;
  assign req_refuse = req_valid && busy;
  assign wdat_ready = (state_q == ST_FILL);
  assign rdat_valid = (state_q == ST_SEND);
  assign mem_valid  = (state_q == ST_ISSUE);
  assign mem_line_addr = calc_line;
  assign mem_offset = calc_off;
  assign mem_len    = calc_len;
  assign mem_store  = wr_q;
  assign mem_wdata  = buf_line;
  assign done       = done_q;
  assign retry      = retry_q;
  assign drained    = drained_q;

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_be
    localparam logic [CNT_W-1:0] POS = CNT_W'(g);
    assign mem_wbe[g] = wr_q && (POS >= {1'b0, calc_off}) &&
                        (POS < ({1'b0, calc_off} + calc_len));
  end

  assign fill_last  = ({1'b0, idx_q} == calc_len - CNT_W'(1));
  assign send_last  = ({1'b0, idx_q} == ch_len_q - CNT_W'(1));
  assign chunk_back = wr_q ? mem_ack : mem_rvalid;

  // ---------------- sequencing ----------------
  always_comb begin
    state_n    = state_q;
    finish_now = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_n = req_write ? ST_FILL : ST_ISSUE;
      ST_FILL:  if (wdat_valid && fill_last) state_n = ST_ISSUE;
      ST_ISSUE: if (mem_ready) state_n = ST_WAIT;
      ST_WAIT: begin
        if (chunk_back) begin
          if (!wr_q) begin
            state_n = ST_SEND;
          end else if (issued_q == len_q) begin
            state_n    = ST_IDLE;
            finish_now = 1'b1;
          end else begin
            state_n = ST_FILL;
          end
        end
      end
      ST_SEND: begin
        if (rdat_ready && send_last) begin
          if (completed_q == len_q) begin
            state_n    = ST_IDLE;
            finish_now = 1'b1;
          end else begin
            state_n = ST_ISSUE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      start_q     <= '0;
      len_q       <= '0;
      wr_q        <= 1'b0;
      issued_q    <= '0;
      completed_q <= '0;
      idx_q       <= '0;
      ch_off_q    <= '0;
      ch_len_q    <= '0;
      finish_q    <= 1'b0;
      done_q      <= 1'b0;
      retry_q     <= 1'b0;
      refused_q   <= 1'b0;
      drained_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      finish_q  <= finish_now;
      done_q    <= finish_q;
      retry_q   <= finish_q && refused_q;
      refused_q <= (refused_q && !finish_q) || req_refuse;
      drained_q <= drain_req && (state_n == ST_IDLE);

      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            start_q     <= req_addr;
            len_q       <= req_len;
            wr_q        <= req_write;
            issued_q    <= '0;
            completed_q <= '0;
            idx_q       <= '0;
          end
        end
        ST_FILL: begin
          if (wdat_valid) idx_q <= fill_last ? '0 : idx_q + OFF_W'(1);
        end
        ST_ISSUE: begin
          if (mem_ready) begin
            issued_q <= issued_q + LEN_W'(calc_len);
            ch_off_q <= calc_off;
            ch_len_q <= calc_len;
          end
        end
        ST_WAIT: begin
          if (chunk_back) begin
            completed_q <= issued_q;
            idx_q       <= '0;
          end
        end
        ST_SEND: begin
          if (rdat_ready) idx_q <= send_last ? '0 : idx_q + OFF_W'(1);
        end
        default: ;
      endcase
    end
  end

  // ---------------- checks ----------------
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> busy);

  a_r2_transfer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(start_q) && $stable(len_q) && $stable(wr_q))));

  a_r3_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) &&
                  (({1'b0, mem_offset} + mem_len) <= CNT_W'(LINE_BYTES)));

  a_r4_later_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && issued_q != '0) |-> (mem_offset == '0));

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_line_addr) &&
                                  $stable(mem_len) && $stable(mem_offset));

  a_r5_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && chunk_back) |=> !mem_valid);

  a_r5_progress_order: assert property (@(posedge clk) disable iff (!rst_n)
    (completed_q <= issued_q) && (issued_q <= len_q));

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> done);

  a_r9_retry_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> done);

  a_r10_drained_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !busy);
endmodule

// File: tb/dma_line_splitter_tb.sv
module dma_line_splitter_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int LB     = 16;
  localparam int OFF_W  = $clog2(LB);
  localparam int CNT_W  = OFF_W + 1;
  localparam int MEMSZ  = 512;
  localparam int NVEC   = 8;

  localparam int VADDR [NVEC] = '{'h10, 'h10, 'h23, 'h23, 'h4F, 'h40, 'h2E, 'h5C};
  localparam int VLEN  [NVEC] = '{16,   16,   40,   40,   1,    16,   5,    60};
  localparam bit VWR   [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_write = 1'b0;
  logic req_accept, req_refuse, busy, done, retry, drained;
  logic drain_req = 1'b0;
  logic wdat_valid = 1'b0;
  logic wdat_ready;
  logic [7:0] wdat_byte = '0;
  logic rdat_valid;
  logic rdat_ready = 1'b0;
  logic [7:0] rdat_byte;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_line_addr;
  logic [OFF_W-1:0] mem_offset;
  logic [CNT_W-1:0] mem_len;
  logic mem_store;
  logic [LB*8-1:0] mem_wdata;
  logic [LB-1:0] mem_wbe;
  logic mem_ack = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [LB*8-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [7:0] model [MEMSZ];

  always #2.5 clk = ~clk;

  dma_line_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_write(req_write), .req_accept(req_accept), .req_refuse(req_refuse),
    .busy(busy), .done(done), .retry(retry),
    .drain_req(drain_req), .drained(drained),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_byte(rdat_byte),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line_addr(mem_line_addr),
    .mem_offset(mem_offset), .mem_len(mem_len), .mem_store(mem_store),
    .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(input int vec, input int k);
    return 8'(k * 13 + vec * 29 + 7);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One transfer, driven and answered one negedge step at a time.
  task automatic run_req(input int addr, input int len, input bit wr, input int vec,
                         input bit inj_refuse, input bit use_drain);
    int sent = 0, wpos = 0, rpos = 0, nchunk = 0, waitc = -1, rstall = 0, steps = 0;
    int resp_line = 0, exp_off, exp_len, exp_line, exp_chunks;
    bit held = 1'b0;
    bit be_ok, wd_ok;
    exp_chunks = ((addr % LB) + len + LB - 1) / LB;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_write = wr;
    #1;
    chk(req_accept && !req_refuse, "R1 accept", {req_accept, req_refuse}, 2'b10);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R1 busy", busy, 1);
    while (busy && steps < 4000) begin
      wdat_valid = 1'b0; mem_ready = 1'b0; mem_ack = 1'b0; mem_rvalid = 1'b0;
      rdat_ready = 1'b0; req_valid = 1'b0;
      if (wdat_ready) begin
        wdat_valid = 1'b1; wdat_byte = wpat(vec, wpos); wpos++;
      end
      if (mem_valid) begin
        if (nchunk % 2 == 1 && !held) begin
          held = 1'b1;
        end else begin
          held = 1'b0;
          exp_off  = (sent == 0) ? (addr % LB) : 0;
          exp_len  = (len - sent < LB - exp_off) ? (len - sent) : (LB - exp_off);
          exp_line = (addr + sent) & ~(LB - 1);
          if (sent == 0)
            chk(mem_offset == OFF_W'(exp_off) && mem_len == CNT_W'(exp_len) &&
                mem_line_addr == ADDR_W'(exp_line), "R3 first chunk",
                {mem_line_addr, 8'(mem_offset), 8'(mem_len)},
                {ADDR_W'(exp_line), 8'(exp_off), 8'(exp_len)});
          else
            chk(mem_offset == OFF_W'(exp_off) && mem_len == CNT_W'(exp_len) &&
                mem_line_addr == ADDR_W'(exp_line), "R4 later chunk",
                {mem_line_addr, 8'(mem_offset), 8'(mem_len)},
                {ADDR_W'(exp_line), 8'(exp_off), 8'(exp_len)});
          chk(mem_store == wr, "R6 direction", mem_store, wr);
          if (wr) begin
            be_ok = 1'b1; wd_ok = 1'b1;
            for (int j = 0; j < LB; j++) begin
              if (mem_wbe[j] != (j >= exp_off && j < exp_off + exp_len)) be_ok = 1'b0;
              if (j >= exp_off && j < exp_off + exp_len) begin
                if (mem_wdata[j*8 +: 8] != wpat(vec, sent + j - exp_off)) wd_ok = 1'b0;
                model[exp_line + j] = mem_wdata[j*8 +: 8];
              end
            end
            chk(be_ok, "R6 byte enables", mem_wbe, 0);
            chk(wd_ok, "R6 write data", mem_wdata[63:0], 0);
          end
          mem_ready = 1'b1;
          resp_line = exp_line;
          sent += exp_len;
          nchunk++;
          waitc = 2;
        end
      end else if (waitc > 0) begin
        waitc--;
      end else if (waitc == 0) begin
        waitc = -1;
        if (wr) mem_ack = 1'b1;
        else begin
          mem_rvalid = 1'b1;
          for (int j = 0; j < LB; j++) mem_rdata[j*8 +: 8] = model[resp_line + j];
        end
      end
      if (rdat_valid) begin
        if (rstall % 3 != 2) begin
          rdat_ready = 1'b1;
          chk(rdat_byte == model[addr + rpos], "R7 read byte", rdat_byte, model[addr + rpos]);
          rpos++;
        end
        rstall++;
      end
      if (use_drain) chk(!drained, "R10 drained while busy", drained, 0);
      if (inj_refuse && steps == 2) begin
        req_valid = 1'b1; req_addr = 'h1F3; req_len = 3; req_write = ~wr;
        #1;
        chk(req_refuse && !req_accept, "R2 refuse", {req_accept, req_refuse}, 2'b01);
      end
      @(negedge clk);
      steps++;
    end
    wdat_valid = 1'b0; mem_ready = 1'b0; mem_ack = 1'b0; mem_rvalid = 1'b0;
    rdat_ready = 1'b0; req_valid = 1'b0;
    chk(steps < 4000, "R8 transfer ends", steps, 4000);
    chk(nchunk == exp_chunks, "R5 chunk count", nchunk, exp_chunks);
    chk(sent == len, "R5 bytes sent", sent, len);
    if (wr) chk(wpos == len, "R6 stream bytes used", wpos, len);
    else chk(rpos == len, "R7 bytes emitted", rpos, len);
    chk(!done, "R8 done not before idle", done, 0);
    chk(drained == use_drain, "R10 drained after idle", drained, use_drain);
    @(negedge clk);
    chk(done, "R8 done pulse", done, 1);
    chk(retry == inj_refuse, "R9 retry", retry, inj_refuse);
    @(negedge clk);
    chk(!done && !retry, "R8 single pulse", {done, retry}, 0);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) model[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_valid && !wdat_ready && !rdat_valid && !done && !retry && !drained,
        "R11 reset state",
        {busy, mem_valid, wdat_ready, rdat_valid, done, retry, drained}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid && !done, "R11 after reset", {busy, mem_valid, done}, 0);

    for (int v = 0; v < NVEC; v++) run_req(VADDR[v], VLEN[v], VWR[v], v, 1'b0, 1'b0);

    // Refusal during a multi-line write, with a drain pending.
    drain_req = 1'b1;
    run_req('h101, 34, 1'b1, 8, 1'b1, 1'b1);
    // Read it back, refusal again; the refused request must not disturb it.
    run_req('h101, 34, 1'b0, 9, 1'b1, 1'b1);
    drain_req = 1'b0;
    @(negedge clk);
    chk(!drained, "R10 drained drops", drained, 0);
    drain_req = 1'b1;
    @(negedge clk);
    chk(drained, "R10 drained idle", drained, 1);
    drain_req = 1'b0;
    // Single byte read at the last offset of a line.
    run_req('h10F, 1, 1'b0, 10, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule